// File: doc/BRIEF.md
# Load/Store Access Unit for a 32-bit Integer Core

This unit carries out the memory instructions of a 32-bit integer core against a single word-wide synchronous data port. Each cycle it may receive one instruction word together with the base register value and the value to be stored. From the opcode it tells a load from a store. From the three-bit function field it picks the access size and, for loads, whether the result is sign- or zero-extended. It adds the sign-extended 12-bit offset to the base to form a byte address. A load takes that offset from one contiguous field. A store rebuilds it from two separate fields.

Stores produce a write strobe per byte lane and a data word with the narrow value copied into every lane. Loads issue a read, and one cycle later the unit shifts the returned word down to the addressed byte or halfword, extends it, and presents it with a destination-register write enable and index. A misaligned access or an unrecognised function code raises a flag in the request cycle, and no memory request is made.

The control is a two-state machine. In ST_IDLE no load result is pending. In ST_RESP a load was issued in the previous cycle and its result is on the output. Transitions: T_ISSUE (any state to ST_RESP, taken when a load request leaves this cycle), T_DRAIN (ST_RESP to ST_IDLE, taken when no load leaves this cycle) and T_HOLD (ST_IDLE to ST_IDLE, no load). A new request may be accepted in ST_RESP, so back-to-back loads stay in ST_RESP.

Top module: `lsu_unit`

## Requirements
- R1: The byte address is the base value plus the 12-bit offset sign-extended to 32 bits. For a load (opcode 0000011) the offset is instruction bits 31:20. For a store (opcode 0100011) offset bits 11:5 are instruction bits 31:25 and offset bits 4:0 are instruction bits 11:7.
- R2: A store drives mem_en=1 and mem_we=1. Its strobe uses bit i for byte lane i (data bits 8i+7:8i). A byte store (function 000) sets only lane addr[1:0]. A halfword store (001) sets lanes 0-1 when addr[1]=0 and lanes 2-3 otherwise. A word store (010) sets all four lanes.
- R3: The store data is the store value's low byte copied into all four lanes for a byte store, its low halfword copied into both halves for a halfword store, and the full value for a word store.
- R4: A load result is the addressed byte or halfword of the returned word, taken from lane addr[1:0]. Function 000 gives a sign-extended byte, 100 a zero-extended byte, 001 a sign-extended halfword, 101 a zero-extended halfword and 010 the full word.
- R5: A load drives mem_en=1 and mem_we=0. In the following cycle rd_we=1, rd_idx equals instruction bits 11:7 and rd_data carries the result. In any cycle that does not follow a load request, rd_we=0. Stores never assert rd_we.
- R6: A legal halfword access at an odd address, or a legal word access with addr[1:0] not 00, asserts misaligned in that cycle and makes no memory request (mem_en=0), so no write-back follows.
- R7: A load whose function field is 011, 110 or 111, or a store whose function field is 1xx or 011, asserts illegal and makes no memory request. misaligned stays 0 in that case.
- R8: With in_valid=0, or with any opcode other than the two above, mem_en, misaligned and illegal are all 0.
- R9: A load result can appear in the same cycle as a new load, store or flagged request is accepted, and both are correct.
- R10: While rst_n is low and in the first cycle after it rises, rd_we is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_instr | input | 32 | Instruction word |
| in_base | input | 32 | Base register value |
| in_store | input | 32 | Store data register value |
| mem_en | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_strb | output | 4 | Byte-lane write strobes |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rdata | input | 32 | Read word, valid one cycle after a read request |
| misaligned | output | 1 | Request dropped for misalignment |
| illegal | output | 1 | Request dropped for an unknown function code |
| rd_we | output | 1 | Destination write enable for a load result |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 32 | Aligned, extended load result |

## Verification
The write-back of one load and the acceptance of the next request meet in a single cycle whenever instructions arrive back to back. The bench provokes this by presenting a new instruction every cycle. It first runs a directed load-then-store and load-then-misaligned pair, then a long random mix. In each cycle it checks the pending load result against a value it captured from its own memory model at issue time. In the same cycle it checks the new request's address, strobes, data and flags, so a write-back corrupted by the new request's fields is caught.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } lsu_state_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12
) (
    input  logic             valid,
    input  logic [6:0]       opcode,
    input  logic [2:0]       func,
    input  logic [6:0]       imm_hi,
    input  logic [4:0]       imm_lo_load,
    input  logic [4:0]       imm_lo_store,
    output logic             do_load,
    output logic             do_store,
    output logic             bad_func,
    output acc_size_t        size,
    output logic             zero_ext,
    output logic [XLEN-1:0]  offset
);
    localparam int EXT_W = XLEN - IMM_W;

    logic             is_ld_op;
    logic             is_st_op;
    logic             func_ok;
    logic [IMM_W-1:0] imm_raw;

    assign is_ld_op = valid && (opcode == OPC_LOAD);
    assign is_st_op = valid && (opcode == OPC_STORE);

    always_comb begin
        func_ok  = 1'b0;
        size     = SZ_BYTE;
        zero_ext = 1'b0;
        if (is_ld_op) begin
            unique case (func)
                3'b000:  begin func_ok = 1'b1; size = SZ_BYTE; end
                3'b001:  begin func_ok = 1'b1; size = SZ_HALF; end
                3'b010:  begin func_ok = 1'b1; size = SZ_WORD; end
                3'b100:  begin func_ok = 1'b1; size = SZ_BYTE; zero_ext = 1'b1; end
                3'b101:  begin func_ok = 1'b1; size = SZ_HALF; zero_ext = 1'b1; end
                default: func_ok = 1'b0;
            endcase
        end else if (is_st_op) begin
            unique case (func)
                3'b000:  begin func_ok = 1'b1; size = SZ_BYTE; end
                3'b001:  begin func_ok = 1'b1; size = SZ_HALF; end
                3'b010:  begin func_ok = 1'b1; size = SZ_WORD; end
                default: func_ok = 1'b0;
            endcase
        end
    end

    assign do_load  = is_ld_op && func_ok;
    assign do_store = is_st_op && func_ok;
    assign bad_func = (is_ld_op || is_st_op) && !func_ok;

    // The low five offset bits sit in different instruction fields per kind.
    assign imm_raw = is_st_op ? {imm_hi, imm_lo_store} : {imm_hi, imm_lo_load};
    assign offset  = {{EXT_W{imm_raw[IMM_W-1]}}, imm_raw};

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  acc_size_t          size,
    input  logic [$clog2(XLEN/8)-1:0] lane_off,
    input  logic [XLEN-1:0]    data_in,
    output logic [XLEN/8-1:0]  strb,
    output logic [XLEN-1:0]    wdata
);
    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int HALF_SEL = g % 2;
        localparam logic [OFF_W-1:0] LANE_ID = OFF_W'(g);

        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    strb[g]          = (lane_off == LANE_ID);
                    wdata[g*8 +: 8]  = data_in[7:0];
                end
                SZ_HALF: begin
                    strb[g]          = (lane_off[OFF_W-1:1] == LANE_ID[OFF_W-1:1]);
                    wdata[g*8 +: 8]  = data_in[HALF_SEL*8 +: 8];
                end
                default: begin
                    strb[g]          = 1'b1;
                    wdata[g*8 +: 8]  = data_in[g*8 +: 8];
                end
            endcase
        end
    end

endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
    import lsu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  acc_size_t          size,
    input  logic               zero_ext,
    input  logic [$clog2(XLEN/8)-1:0] lane_off,
    input  logic [XLEN-1:0]    rdata,
    output logic [XLEN-1:0]    result
);
    localparam int OFF_W = $clog2(XLEN / 8);

    logic [XLEN-1:0] shifted;
    logic            fill;

    assign shifted = rdata >> {lane_off, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                fill   = !zero_ext && shifted[7];
                result = {{(XLEN-8){fill}}, shifted[7:0]};
            end
            SZ_HALF: begin
                fill   = !zero_ext && shifted[15];
                result = {{(XLEN-16){fill}}, shifted[15:0]};
            end
            default: begin
                fill   = 1'b0;
                result = rdata;
            end
        endcase
    end

    logic unused_off;
    assign unused_off = (OFF_W == 0);

endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
    import lsu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12,
    parameter int REG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_instr,
    input  logic [XLEN-1:0]   in_base,
    input  logic [XLEN-1:0]   in_store,
    output logic              mem_en,
    output logic              mem_we,
    output logic [XLEN/8-1:0] mem_strb,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              misaligned,
    output logic              illegal,
    output logic              rd_we,
    output logic [REG_W-1:0]  rd_idx,
    output logic [XLEN-1:0]   rd_data
);
    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);

    logic            do_load;
    logic            do_store;
    logic            bad_func;
    acc_size_t       size;
    logic            zero_ext;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] eff_addr;
    logic            mis_hit;
    logic            issue_ld;
    logic [XLEN-1:0] aligned;

    lsu_state_t      state_q;
    lsu_state_t      state_d;
    acc_size_t       cap_size_q;
    logic            cap_zext_q;
    logic [OFF_W-1:0] cap_off_q;
    logic [REG_W-1:0] cap_rd_q;

    lsu_decode #(.XLEN(XLEN), .IMM_W(IMM_W)) u_dec (
        .valid        (in_valid),
        .opcode       (in_instr[6:0]),
        .func         (in_instr[14:12]),
        .imm_hi       (in_instr[31:25]),
        .imm_lo_load  (in_instr[24:20]),
        .imm_lo_store (in_instr[11:7]),
        .do_load      (do_load),
        .do_store     (do_store),
        .bad_func     (bad_func),
        .size         (size),
        .zero_ext     (zero_ext),
        .offset       (offset)
    );

    assign eff_addr = in_base + offset;

    always_comb begin
        unique case (size)
            SZ_HALF: mis_hit = eff_addr[0];
            SZ_WORD: mis_hit = (eff_addr[OFF_W-1:0] != '0);
            default: mis_hit = 1'b0;
        endcase
    end

    assign misaligned = (do_load || do_store) && mis_hit;
    assign illegal    = bad_func;
    assign mem_en     = (do_load || do_store) && !mis_hit;
    assign mem_we     = do_store && !mis_hit;
    assign mem_addr   = eff_addr;
    assign issue_ld   = do_load && !mis_hit;

    logic [LANES-1:0] lane_strb;
    lsu_store_lane #(.XLEN(XLEN)) u_st (
        .size     (size),
        .lane_off (eff_addr[OFF_W-1:0]),
        .data_in  (in_store),
        .strb     (lane_strb),
        .wdata    (mem_wdata)
    );
    assign mem_strb = mem_we ? lane_strb : '0;

    // Next-state selection: T_ISSUE / T_DRAIN / T_HOLD.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = issue_ld ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = issue_ld ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_size_q <= SZ_BYTE;
            cap_zext_q <= 1'b0;
            cap_off_q  <= '0;
            cap_rd_q   <= '0;
        end else if (issue_ld) begin
            cap_size_q <= size;
            cap_zext_q <= zero_ext;
            cap_off_q  <= eff_addr[OFF_W-1:0];
            cap_rd_q   <= in_instr[11:7];
        end
    end

    lsu_load_align #(.XLEN(XLEN)) u_ld (
        .size     (cap_size_q),
        .zero_ext (cap_zext_q),
        .lane_off (cap_off_q),
        .rdata    (mem_rdata),
        .result   (aligned)
    );

    always_comb begin
        rd_we   = 1'b0;
        rd_idx  = '0;
        rd_data = '0;
        unique case (state_q)
            ST_RESP: begin
                rd_we   = 1'b1;
                rd_idx  = cap_rd_q;
                rd_data = aligned;
            end
            default: ;
        endcase
    end

    // R5: every read request is followed by a write-back
    a_r5_load_writes_back: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> rd_we);

    // R5: no write-back without a read request one cycle earlier
    a_r5_no_stray_wb: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_en && !mem_we) |=> !rd_we);

    // R6: a misaligned access never reaches memory
    a_r6_misalign_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> !mem_en);

    // R7: an unknown function code makes no request and no misalign flag
    a_r7_illegal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_en && !misaligned));

    // R2: write strobes cover one, two or four lanes on a write
    a_r2_strobe_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> ($countones(mem_strb) == 1 ||
                                $countones(mem_strb) == 2 ||
                                $countones(mem_strb) == 4));

endmodule

// File: tb/lsu_unit_test.sv
module lsu_unit_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_base = '0;
    logic [31:0] in_store = '0;
    logic        mem_en, mem_we, misaligned, illegal, rd_we;
    logic [3:0]  mem_strb;
    logic [31:0] mem_addr, mem_wdata, rd_data;
    logic [31:0] mem_rdata = '0;
    logic [4:0]  rd_idx;

    int n_chk = 0;
    int n_bad = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_val = '0;
    logic [4:0]  pend_rd = '0;
    logic [31:0] mem [16];

    always #(CLK_P/2) clk = ~clk;

    lsu_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_base(in_base), .in_store(in_store), .mem_en(mem_en), .mem_we(mem_we),
        .mem_strb(mem_strb), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .misaligned(misaligned), .illegal(illegal),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // Synchronous data memory: one-cycle read latency, per-lane writes.
    always @(posedge clk) begin
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[5:2]];
        if (mem_en && mem_we) begin
            for (int i = 0; i < 4; i++)
                if (mem_strb[i]) mem[mem_addr[5:2]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
        end
    end

    task automatic chk(input bit ok, input string tag, input [31:0] act, input [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic [31:0] f_ld(input [31:0] w, input [2:0] f3, input [1:0] off);
        logic [31:0] s;
        s = w >> (off * 8);
        case (f3)
            3'b000:  f_ld = {{24{s[7]}}, s[7:0]};
            3'b100:  f_ld = {24'd0, s[7:0]};
            3'b001:  f_ld = {{16{s[15]}}, s[15:0]};
            3'b101:  f_ld = {16'd0, s[15:0]};
            default: f_ld = w;
        endcase
    endfunction

    function automatic [3:0] f_strb(input [2:0] f3, input [1:0] off);
        case (f3)
            3'b000:  f_strb = 4'b0001 << off;
            3'b001:  f_strb = off[1] ? 4'b1100 : 4'b0011;
            default: f_strb = 4'b1111;
        endcase
    endfunction

    function automatic [31:0] f_wd(input [2:0] f3, input [31:0] s);
        case (f3)
            3'b000:  f_wd = {4{s[7:0]}};
            3'b001:  f_wd = {2{s[15:0]}};
            default: f_wd = s;
        endcase
    endfunction

    function automatic [31:0] mk_ld(input [2:0] f3, input [4:0] rd, input [11:0] imm);
        mk_ld = {imm, 5'd3, f3, rd, 7'b0000011};
    endfunction

    function automatic [31:0] mk_st(input [2:0] f3, input [11:0] imm);
        mk_st = {imm[11:5], 5'd9, 5'd3, f3, imm[4:0], 7'b0100011};
    endfunction

    task automatic run_op(input logic v, input [31:0] ins, input [31:0] b, input [31:0] s);
        logic ld, st, lg, mis, ill, en;
        logic [2:0] f3;
        logic [11:0] imm;
        logic [31:0] a;
        @(negedge clk);
        // R5 / R9: result of the previous request, checked while a new one is accepted
        chk(rd_we == pend, "R5 rd_we", {31'd0, rd_we}, {31'd0, pend});
        if (pend) begin
            chk(rd_data == pend_val, "R4 R9 rd_data", rd_data, pend_val);
            chk(rd_idx == pend_rd, "R5 rd_idx", {27'd0, rd_idx}, {27'd0, pend_rd});
        end
        in_valid = v; in_instr = ins; in_base = b; in_store = s;
        #1;
        f3  = ins[14:12];
        ld  = v && ins[6:0] == 7'b0000011;
        st  = v && ins[6:0] == 7'b0100011;
        lg  = ld ? (f3 != 3'b011 && f3 != 3'b110 && f3 != 3'b111) : (f3 <= 3'b010);
        ill = (ld || st) && !lg;
        imm = st ? {ins[31:25], ins[11:7]} : ins[31:20];
        a   = b + {{20{imm[11]}}, imm};
        mis = (ld || st) && lg && ((f3[1:0] == 2'b01 && a[0]) || (f3[1:0] == 2'b10 && a[1:0] != 2'b00));
        en  = (ld || st) && lg && !mis;
        chk(illegal == ill, "R7 illegal", {31'd0, illegal}, {31'd0, ill});
        chk(misaligned == mis, "R6 misaligned", {31'd0, misaligned}, {31'd0, mis});
        chk(mem_en == en, "R8 mem_en", {31'd0, mem_en}, {31'd0, en});
        if (en) begin
            chk(mem_addr == a, "R1 address", mem_addr, a);
            chk(mem_we == st, "R2 mem_we", {31'd0, mem_we}, {31'd0, st});
            if (st) begin
                chk(mem_strb == f_strb(f3, a[1:0]), "R2 strobe", {28'd0, mem_strb}, {28'd0, f_strb(f3, a[1:0])});
                chk(mem_wdata == f_wd(f3, s), "R3 wdata", mem_wdata, f_wd(f3, s));
            end
        end
        pend = en && ld;
        if (pend) begin
            pend_val = f_ld(mem[a[5:2]], f3, a[1:0]);
            pend_rd  = ins[11:7];
        end
    endtask

    initial begin
        int seed;
        for (int i = 0; i < 16; i++) mem[i] = 32'h8421_7F80 ^ (i * 32'h0101_1357);
        mem[2] = 32'h80FF_7F01;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R10: no write-back in reset
        chk(rd_we == 1'b0, "R10 reset rd_we", {31'd0, rd_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_we == 1'b0, "R10 after reset", {31'd0, rd_we}, 32'd0);
        chk(mem_en == 1'b0, "R8 idle mem_en", {31'd0, mem_en}, 32'd0);

        // Directed: R4 each load flavour, R1 negative offset
        run_op(1, mk_ld(3'b000, 5'd1, 12'd11), 32'h0, 0);   // byte lane 3 = 80 -> sign
        run_op(1, mk_ld(3'b100, 5'd2, 12'd11), 32'h0, 0);   // unsigned byte
        run_op(1, mk_ld(3'b001, 5'd3, 12'd10), 32'h0, 0);   // half 80FF signed
        run_op(1, mk_ld(3'b101, 5'd4, 12'd10), 32'h0, 0);   // half unsigned
        run_op(1, mk_ld(3'b010, 5'd5, 12'hFFC), 32'hC, 0);  // R1 offset -4
        run_op(1, mk_ld(3'b010, 5'd6, 12'h800), 32'h808, 0); // R1 offset -2048
        // R2 R3 stores, R9 store right after load
        run_op(1, mk_st(3'b000, 12'd17), 32'h0, 32'h1234_56A5);
        run_op(1, mk_st(3'b001, 12'd22), 32'h0, 32'hDEAD_BEEF);
        run_op(1, mk_st(3'b010, 12'h7FC), 32'hFFFF_F804, 32'hCAFE_F00D);
        run_op(1, mk_ld(3'b000, 5'd7, 12'd17), 32'h0, 0);   // reads back stored byte
        // R6 misaligned, R9 after a load
        run_op(1, mk_ld(3'b001, 5'd8, 12'd1), 32'h0, 0);
        run_op(1, mk_ld(3'b010, 5'd9, 12'd2), 32'h0, 0);
        run_op(1, mk_st(3'b010, 12'd3), 32'h0, 32'h1);
        // R7 illegal codes
        run_op(1, mk_ld(3'b011, 5'd1, 12'd0), 32'h0, 0);
        run_op(1, mk_ld(3'b110, 5'd1, 12'd0), 32'h0, 0);
        run_op(1, mk_st(3'b100, 12'd0), 32'h0, 0);
        // R8 other opcode and invalid slot
        run_op(1, 32'h0000_0013, 32'h0, 0);
        run_op(0, mk_ld(3'b010, 5'd1, 12'd0), 32'h0, 0);

        for (int k = 0; k < 3000; k++) begin
            logic [31:0] ins;
            logic [2:0] f3;
            int sel;
            sel = $urandom_range(0, 9);
            f3  = 3'($urandom_range(0, 7));
            if (sel < 5)      ins = mk_ld(f3, 5'($urandom), 12'($urandom));
            else if (sel < 9) ins = mk_st(f3, 12'($urandom));
            else              ins = $urandom;
            run_op(sel != 0 || k[0], ins, $urandom, $urandom);
        end
        run_op(0, 32'h0, 32'h0, 0);
        run_op(0, 32'h0, 32'h0, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule